// File: doc/BRIEF.md
# Second-Level Cache Allocation Policy Filter

This block sits on the path from first-level cache miss traffic into a second-level cache. For every request it chooses one of three outcomes: look up the cache and use it on a hit, look up and allocate a line on a miss, or send the request around the cache as uncached. It also says whether a write must be copied to the system bus, and which coherence state a written line takes.

The policy depends on a set of configuration inputs: a global enable, a data-only mode, an instruction-only mode, a write-through mode and a test-support mode. With both restriction modes set, the cache is locked. In that state no miss allocates, but write hits still update lines. The configuration is sampled together with each request when that request is accepted. A change therefore applies from the next accepted request on, and never to a decision already issued. Requests and decisions each pass through a valid/ready handshake, and there is one register stage between them.

Top module: `alloc_policy_filter`

## Requirements
- R1: After reset `dec_valid` is 0. A request accepted on a clock edge (`req_valid` and `req_ready` both 1) gives its decision with `dec_valid`=1 after that same edge. `req_ready` is 1 whenever `dec_valid` is 0 or `dec_ready` is 1.
- R2: While `dec_valid`=1 and `dec_ready`=0, `dec_valid` and every decision output hold their values.
- R3: Request kind encoding is 0 instruction read, 1 data read, 2 data store, 3 data push (a line pushed out of the first-level data cache by a flush or store-back). Line state encoding is 0 invalid, 1 exclusive, 2 modified, 3 keep (no state change). With the enable clear, every request gives lookup=0, allocate=0, bypass=1 and state keep, and sysbus=1 only for kinds 2 and 3.
- R4: The configuration in effect is the value present when the request is accepted. Changing it while a decision is held does not alter that decision.
- R5: In data-only mode an instruction read that hits is served from the cache (lookup=1, bypass=0). An instruction read that misses bypasses with allocate=0. Data misses still allocate.
- R6: In instruction-only mode a data request that hits, stores included, uses the cache. A data miss of any kind bypasses with allocate=0, and stores that miss go to the bus. Instruction misses still allocate.
- R7: With both restriction modes set, no request allocates. A store hit still updates the line (modified in write-back mode).
- R8: In write-back mode a store hit or an allocated store miss gives state modified with sysbus=0. An allocated read miss gives exclusive. A read hit gives keep.
- R9: In write-through mode every store has sysbus=1. A line that a store writes or allocates gets exclusive, and no request gives modified.
- R10: With test-support off, a push that hits gives state invalid and sysbus=1 with no bypass. A push that misses gives bypass=1 and sysbus=1.
- R11: With test-support on, a push is written only into the cache (sysbus=0). It gives modified, or exclusive in write-through mode. It allocates on a miss when data allocation is permitted. Otherwise it bypasses to the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be accepted |
| req_kind | input | 2 | Request kind (R3 encoding) |
| req_hit | input | 1 | Tag lookup result: 1 hit |
| cfg_enable | input | 1 | Cache enable |
| cfg_data_only | input | 1 | Data-only mode |
| cfg_instr_only | input | 1 | Instruction-only mode |
| cfg_write_thru | input | 1 | Write-through mode |
| cfg_test_mode | input | 1 | Test-support mode |
| dec_valid | output | 1 | Decision present |
| dec_ready | input | 1 | Decision consumed |
| dec_lookup | output | 1 | Request uses the cache arrays |
| dec_allocate | output | 1 | Allocate a line for this miss |
| dec_bypass | output | 1 | Treat as uncached |
| dec_sysbus | output | 1 | Write goes to the system bus |
| dec_state | output | 2 | Next line state (R3 encoding) |

## Verification
Two functions can coincide in one cycle. One is the release of a decision held under backpressure. The other is the acceptance of the next request, which carries a different configuration. The bench holds `dec_ready` low with a second request waiting and changes the enable in that window. It then raises `dec_ready` and judges the result. The held decision must stay as issued. The queued request must come out the very next cycle, decided under the configuration present at its own acceptance.

// File: rtl/apf_pkg.sv
package apf_pkg;
  localparam int KIND_W  = 2;
  localparam int STATE_W = 2;

  typedef enum logic [KIND_W-1:0] {
    K_IFETCH = 2'd0,
    K_DREAD  = 2'd1,
    K_DSTORE = 2'd2,
    K_DPUSH  = 2'd3
  } kind_e;

  typedef enum logic [STATE_W-1:0] {
    S_INV  = 2'd0,
    S_EXC  = 2'd1,
    S_MOD  = 2'd2,
    S_KEEP = 2'd3
  } state_e;

  typedef struct packed {
    logic   lookup;
    logic   allocate;
    logic   bypass;
    logic   sysbus;
    state_e state;
  } dec_t;

  localparam int DEC_W = $bits(dec_t);
endpackage

// File: rtl/apf_decide.sv
module apf_decide
  import apf_pkg::*;
(
  input  kind_e kind,
  input  logic  hit,
  input  logic  enable,
  input  logic  data_only,
  input  logic  instr_only,
  input  logic  write_thru,
  input  logic  test_mode,
  output dec_t  dec
);
  logic is_instr, is_store, is_push, is_write, may_alloc;
  state_e wr_state;

  always_comb begin
    is_instr  = (kind == K_IFETCH);
    is_store  = (kind == K_DSTORE);
    is_push   = (kind == K_DPUSH);
    is_write  = is_store | is_push;
    may_alloc = is_instr ? !data_only : !instr_only;
    wr_state  = write_thru ? S_EXC : S_MOD;

    dec.lookup   = 1'b1;
    dec.allocate = 1'b0;
    dec.bypass   = 1'b0;
    dec.sysbus   = 1'b0;
    dec.state    = S_KEEP;

    if (!enable) begin
      dec.lookup = 1'b0;
      dec.bypass = 1'b1;
      dec.sysbus = is_write;
    end else if (is_push && !test_mode) begin
      dec.sysbus = 1'b1;
      if (hit) dec.state  = S_INV;
      else     dec.bypass = 1'b1;
    end else if (hit) begin
      if (is_write) dec.state = wr_state;
      dec.sysbus = is_store & write_thru;
    end else if (may_alloc) begin
      dec.allocate = 1'b1;
      dec.state    = is_write ? wr_state : S_EXC;
      dec.sysbus   = is_store & write_thru;
    end else begin
      dec.bypass = 1'b1;
      dec.sysbus = is_write;
    end
  end
endmodule

// File: rtl/apf_stage.sv
module apf_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst)           out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (take) out_data <= in_data;
  end

  assert_accept_shows_R1: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/alloc_policy_filter.sv
module alloc_policy_filter
  import apf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_kind,
  input  logic       req_hit,
  input  logic       cfg_enable,
  input  logic       cfg_data_only,
  input  logic       cfg_instr_only,
  input  logic       cfg_write_thru,
  input  logic       cfg_test_mode,
  output logic       dec_valid,
  input  logic       dec_ready,
  output logic       dec_lookup,
  output logic       dec_allocate,
  output logic       dec_bypass,
  output logic       dec_sysbus,
  output logic [1:0] dec_state
);
  dec_t next_dec, held_dec;
  logic [DEC_W-1:0] held_bits;

  apf_decide u_decide (
    .kind       (kind_e'(req_kind)),
    .hit        (req_hit),
    .enable     (cfg_enable),
    .data_only  (cfg_data_only),
    .instr_only (cfg_instr_only),
    .write_thru (cfg_write_thru),
    .test_mode  (cfg_test_mode),
    .dec        (next_dec)
  );

  apf_stage #(.W(DEC_W)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (next_dec),
    .out_valid (dec_valid),
    .out_ready (dec_ready),
    .out_data  (held_bits)
  );

  assign held_dec     = dec_t'(held_bits);
  assign dec_lookup   = held_dec.lookup;
  assign dec_allocate = held_dec.allocate;
  assign dec_bypass   = held_dec.bypass;
  assign dec_sysbus   = held_dec.sysbus;
  assign dec_state    = held_dec.state;

  logic accept;
  assign accept = req_valid && req_ready;

  assert_disabled_bypass_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && !cfg_enable) |=> (dec_bypass && !dec_lookup && !dec_allocate));

  assert_locked_no_alloc_R7: assert property (@(posedge clk) disable iff (rst)
    (accept && cfg_data_only && cfg_instr_only) |=> !dec_allocate);

  assert_wt_never_mod_R9: assert property (@(posedge clk) disable iff (rst)
    (accept && cfg_write_thru) |=> (dec_state != 2'd2));

  assert_wt_store_bus_R9: assert property (@(posedge clk) disable iff (rst)
    (accept && cfg_write_thru && req_kind == 2'd2) |=> dec_sysbus);

  assert_bypass_excl_R5: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> !(dec_bypass && dec_allocate));
endmodule

// File: tb/tb_alloc_policy_filter.sv
module tb_alloc_policy_filter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_ready, req_hit;
  logic [1:0] req_kind;
  logic cfg_enable, cfg_data_only, cfg_instr_only, cfg_write_thru, cfg_test_mode;
  logic dec_valid, dec_ready, dec_lookup, dec_allocate, dec_bypass, dec_sysbus;
  logic [1:0] dec_state;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alloc_policy_filter dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_hit(req_hit), .cfg_enable(cfg_enable),
    .cfg_data_only(cfg_data_only), .cfg_instr_only(cfg_instr_only),
    .cfg_write_thru(cfg_write_thru), .cfg_test_mode(cfg_test_mode),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_lookup(dec_lookup),
    .dec_allocate(dec_allocate), .dec_bypass(dec_bypass),
    .dec_sysbus(dec_sysbus), .dec_state(dec_state)
  );

  // expected packing: {lookup, allocate, bypass, sysbus, state[1:0]}
  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] observed();
    return {dec_valid, dec_lookup, dec_allocate, dec_bypass, dec_sysbus, dec_state};
  endfunction

  task automatic set_cfg(input logic en, input logic dm, input logic im,
                         input logic wt, input logic ts);
    cfg_enable = en; cfg_data_only = dm; cfg_instr_only = im;
    cfg_write_thru = wt; cfg_test_mode = ts;
  endtask

  task automatic issue(input string tag, input logic [1:0] kind, input logic hit,
                       input logic [5:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_hit = hit;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, observed(), {1'b1, exp});
  endtask

  task automatic t_reset_R1();
    check("R1 reset dec_valid", {6'd0, dec_valid}, 7'd0);
    check("R1 reset req_ready", {6'd0, req_ready}, 7'd1);
  endtask

  task automatic t_disabled_R3();
    set_cfg(0, 0, 0, 0, 0);
    issue("R3 disabled ifetch", 2'd0, 1'b1, 6'b001011);
    issue("R3 disabled store",  2'd2, 1'b1, 6'b001111);
    issue("R3 disabled push",   2'd3, 1'b0, 6'b001111);
  endtask

  task automatic t_writeback_R8();
    set_cfg(1, 0, 0, 0, 0);
    issue("R8 read hit",    2'd1, 1'b1, 6'b100011);
    issue("R8 read miss",   2'd1, 1'b0, 6'b110001);
    issue("R8 store hit",   2'd2, 1'b1, 6'b100010);
    issue("R8 store miss",  2'd2, 1'b0, 6'b110010);
  endtask

  task automatic t_writethru_R9();
    set_cfg(1, 0, 0, 1, 0);
    issue("R9 store hit",   2'd2, 1'b1, 6'b100101);
    issue("R9 store miss",  2'd2, 1'b0, 6'b110101);
  endtask

  task automatic t_data_only_R5();
    set_cfg(1, 1, 0, 0, 0);
    issue("R5 ifetch hit",  2'd0, 1'b1, 6'b100011);
    issue("R5 ifetch miss", 2'd0, 1'b0, 6'b101011);
    issue("R5 dread miss",  2'd1, 1'b0, 6'b110001);
  endtask

  task automatic t_instr_only_R6();
    set_cfg(1, 0, 1, 0, 0);
    issue("R6 store hit",   2'd2, 1'b1, 6'b100010);
    issue("R6 dread miss",  2'd1, 1'b0, 6'b101011);
    issue("R6 store miss",  2'd2, 1'b0, 6'b101111);
    issue("R6 ifetch miss", 2'd0, 1'b0, 6'b110001);
  endtask

  task automatic t_locked_R7();
    set_cfg(1, 1, 1, 0, 0);
    issue("R7 ifetch miss", 2'd0, 1'b0, 6'b101011);
    issue("R7 store miss",  2'd2, 1'b0, 6'b101111);
    issue("R7 store hit",   2'd2, 1'b1, 6'b100010);
    set_cfg(1, 1, 1, 0, 1);
    issue("R7 test push miss", 2'd3, 1'b0, 6'b101111);
  endtask

  task automatic t_push_R10();
    set_cfg(1, 0, 0, 0, 0);
    issue("R10 push hit",  2'd3, 1'b1, 6'b100100);
    issue("R10 push miss", 2'd3, 1'b0, 6'b101111);
  endtask

  task automatic t_test_push_R11();
    set_cfg(1, 0, 0, 0, 1);
    issue("R11 push hit wb",  2'd3, 1'b1, 6'b100010);
    issue("R11 push miss wb", 2'd3, 1'b0, 6'b110010);
    set_cfg(1, 0, 0, 1, 1);
    issue("R11 push hit wt",  2'd3, 1'b1, 6'b100001);
  endtask

  // Held decision under backpressure while the next request waits with a new config
  task automatic t_backpressure_R2_R4();
    set_cfg(1, 0, 0, 0, 0);
    @(negedge clk);
    dec_ready = 1'b0;
    req_valid = 1'b1; req_kind = 2'd2; req_hit = 1'b1;
    @(negedge clk);
    check("R1 first decision", observed(), {1'b1, 6'b100010});
    check("R1 ready low when held", {6'd0, req_ready}, 7'd0);
    req_kind = 2'd1; req_hit = 1'b0;
    cfg_enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R2 held under backpressure", observed(), {1'b1, 6'b100010});
    check("R4 held decision unaffected by enable", observed(), {1'b1, 6'b100010});
    dec_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R4 queued request uses config at acceptance", observed(), {1'b1, 6'b001011});
    cfg_enable = 1'b1;
    @(negedge clk);
    check("R1 drains to idle", {6'd0, dec_valid}, 7'd0);
    issue("R4 enable applies to next request", 2'd1, 1'b0, 6'b110001);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_kind = 2'd0; req_hit = 1'b0;
    dec_ready = 1'b1;
    set_cfg(0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_R1();
    t_disabled_R3();
    t_writeback_R8();
    t_writethru_R9();
    t_data_only_R5();
    t_instr_only_R6();
    t_locked_R7();
    t_push_R10();
    t_test_push_R11();
    t_backpressure_R2_R4();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule